// File: doc/BRIEF.md
# I2C SCL timing generator

This block generates the serial clock for an I2C master and marks the moments at which the bit-level controller must move SDA. The clock is built from a functional clock divided by a power of two (exponent 0 to 7). Four cycle counts, all in prescaled ticks, shape the waveform: high length, low length, START/STOP setup-and-hold, and data-valid delay. The generator drives SCL as an open-drain output (`scl_o` = 1 releases the line). It watches the line through `scl_in`, so a target that holds SCL low stretches the high phase.

The controller issues one of three commands: START, BIT or STOP. After a START the clock stays parked low until the next command. A BIT runs one full low/high cycle. A STOP runs a low phase, releases SCL and, after the setup time, asks for the SDA rise. The four timing counts are captured only while `en` is low. An automatic mode derives the low, setup and data-valid counts from the high count.

States: `ST_IDLE` (bus released), `ST_START_SU` (SCL high before the SDA fall), `ST_START_HD` (SCL high after the SDA fall), `ST_PARK` (SCL low, waiting for a command), `ST_LOW` (timed low phase), `ST_WAIT_HI` (SCL released, waiting to see it high), `ST_HIGH` (timed high phase) and `ST_STOP_SU` (SCL high before the SDA rise).

Transitions:
- IDLE→START_SU on START.
- START_SU→START_HD and START_HD→PARK when the setup count ends.
- PARK→LOW on BIT or STOP.
- LOW→WAIT_HI when the low count ends.
- WAIT_HI→HIGH (BIT) or WAIT_HI→STOP_SU (STOP) once the line is seen high.
- HIGH→LOW when a BIT or STOP is waiting at the end of the high count, otherwise HIGH→PARK.
- STOP_SU→IDLE when the setup count ends.
- Any state→IDLE when `en` is low.

Top module: `i2c_scl_timer`

## Requirements
- R1: After reset, and on the first clock edge on which `en` is low, the block is idle: `scl_o`=1, `cmd_ready`=0 and no strobe is raised.
- R2: A prescaled tick occurs every 2^`pre_exp` functional cycles, and every 2^0 = 1 cycle when the exponent is 0. A timed phase of N ticks therefore lasts N·2^p cycles. The high phase lasts (hi+1)·2^p cycles, from the sample strobe until SCL is pulled low again.
- R3: The low phase of a bit lasts (lo+1)·2^p cycles, from the edge on which the command is accepted (or SCL falls) to the edge on which `scl_o` is released.
- R4: The high count starts only once `scl_in` is seen high. With the line free, `sample_stb` comes 2 cycles after `scl_o` is released. While a target holds the line low, no `sample_stb` comes, and it comes 2 cycles after the line is let go.
- R5: Back-to-back bits repeat every 2^p·(hi+lo+2)+2 functional cycles.
- R6: A START accepted on edge S gives `start_stb` on edge S+(sh+1)·2^p and SCL falls (sh+1)·2^p cycles later, with SCL high during the strobe.
- R7: A STOP runs a (lo+1)·2^p low phase and releases SCL. `stop_stb` comes 2+(sh+1)·2^p cycles after the release, with SCL high. The block then returns to idle with `cmd_ready`=1.
- R8: `drive_stb` comes (dv+1)·2^p cycles after the low phase begins. In the cycle before it, SCL was low.
- R9: `sample_stb` is raised once for each BIT and never for a STOP. At most one of the four strobes is high in any cycle.
- R10: With `auto_cfg`=1 and a high count of 2 or more, the block uses lo = 2·hi, sh = hi and dv = hi/2 (rounded down), ignoring those three inputs.
- R11: With `auto_cfg`=1 and a high count below 2, the block uses lo = 3, sh = 2 and dv = 1.
- R12: Timing inputs (`pre_exp`, counts, `auto_cfg`) are captured on every edge while `en` is low. Changes while `en` is high have no effect.
- R13: `cmd_code` is 1 for START, 2 for BIT and 3 for STOP. A command is taken on an edge with `cmd_valid` and `cmd_ready` both high. `cmd_ready` is high when the block is idle and enabled, when SCL is parked low, and in the last cycle of a high phase. In idle only START has an effect; when parked, START is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Master enable; low loads timing inputs and forces idle |
| auto_cfg | input | 1 | Derive low/setup/data-valid counts from the high count |
| pre_exp | input | PRE_W | Prescaler exponent p, divide by 2^p |
| clkhi_cnt | input | CNT_W | High count hi, phase is hi+1 ticks |
| clklo_cnt | input | CNT_W | Low count lo, phase is lo+1 ticks |
| sethold_cnt | input | CNT_W | START setup/hold and STOP setup count sh |
| datavd_cnt | input | CNT_W | Delay count dv from SCL fall to SDA change |
| cmd_valid | input | 1 | Command present |
| cmd_code | input | 2 | 1 START, 2 BIT, 3 STOP |
| cmd_ready | output | 1 | Command taken on this edge if valid |
| scl_in | input | 1 | Sampled SCL line level |
| scl_o | output | 1 | SCL drive, 0 pulls low, 1 releases |
| start_stb | output | 1 | SDA may fall for START |
| stop_stb | output | 1 | SDA may rise for STOP |
| drive_stb | output | 1 | SDA may change to the next data level |
| sample_stb | output | 1 | SCL seen high, SDA may be sampled |

## Verification
Each result is timed from a registered cause. `start_stb` and the SCL fall come (sh+1)·2^p and 2·(sh+1)·2^p edges after the START is taken. `drive_stb` and the SCL release come (dv+1)·2^p and (lo+1)·2^p edges after a bit is taken. `sample_stb` comes two edges after the line goes high, and the next bit is taken (hi+1)·2^p edges later. The bench timestamps every acceptance edge and every strobe or SCL change by the edge count, observed at the falling clock edge between rising edges. It then compares differences of those counts with the formulas. Values are never read at a guessed absolute time.

// File: rtl/sclt_pkg.sv
package sclt_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START_SU,
        ST_START_HD,
        ST_PARK,
        ST_LOW,
        ST_WAIT_HI,
        ST_HIGH,
        ST_STOP_SU
    } sclt_state_e;

    typedef enum logic [1:0] {
        CMD_NONE  = 2'd0,
        CMD_START = 2'd1,
        CMD_BIT   = 2'd2,
        CMD_STOP  = 2'd3
    } sclt_cmd_e;

endpackage

// File: rtl/sclt_cfg.sv
// Shadow copy of the timing inputs, loaded only while disabled, plus the
// automatic derivation of low/setup/data-valid counts from the high count.
module sclt_cfg #(
    parameter int PRE_W = 3,
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             auto_cfg,
    input  logic [PRE_W-1:0] pre_exp,
    input  logic [CNT_W-1:0] clkhi_cnt,
    input  logic [CNT_W-1:0] clklo_cnt,
    input  logic [CNT_W-1:0] sethold_cnt,
    input  logic [CNT_W-1:0] datavd_cnt,
    output logic [PRE_W-1:0] eff_pre,
    output logic [CNT_W-1:0] eff_hi,
    output logic [CNT_W-1:0] eff_lo,
    output logic [CNT_W-1:0] eff_sh,
    output logic [CNT_W-1:0] eff_dv
);

    localparam logic [CNT_W-1:0] SMALL_LO = CNT_W'(3);
    localparam logic [CNT_W-1:0] SMALL_SH = CNT_W'(2);
    localparam logic [CNT_W-1:0] SMALL_DV = CNT_W'(1);
    localparam logic [CNT_W-1:0] TWO      = CNT_W'(2);

    logic             auto_q;
    logic [PRE_W-1:0] pre_q;
    logic [CNT_W-1:0] hi_q, lo_q, sh_q, dv_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            auto_q <= 1'b0;
            pre_q  <= '0;
            hi_q   <= '0;
            lo_q   <= '0;
            sh_q   <= '0;
            dv_q   <= '0;
        end else if (!en) begin
            auto_q <= auto_cfg;
            pre_q  <= pre_exp;
            hi_q   <= clkhi_cnt;
            lo_q   <= clklo_cnt;
            sh_q   <= sethold_cnt;
            dv_q   <= datavd_cnt;
        end
    end

    always_comb begin
        eff_pre = pre_q;
        eff_hi  = hi_q;
        eff_lo  = lo_q;
        eff_sh  = sh_q;
        eff_dv  = dv_q;
        if (auto_q) begin
            if (hi_q < TWO) begin
                eff_lo = SMALL_LO;
                eff_sh = SMALL_SH;
                eff_dv = SMALL_DV;
            end else begin
                eff_lo = {hi_q[CNT_W-2:0], 1'b0};
                eff_sh = hi_q;
                eff_dv = {1'b0, hi_q[CNT_W-1:1]};
            end
        end
    end

endmodule

// File: rtl/sclt_tick.sv
// Power-of-two prescaler; restarts at each phase boundary so a phase of
// N ticks lasts exactly N * 2^p functional cycles.
module sclt_tick #(
    parameter int PRE_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [PRE_W-1:0] pre_exp,
    output logic             tick
);

    localparam int DIV_W = (1 << PRE_W) - 1;

    logic [DIV_W-1:0] pcnt;
    logic [DIV_W-1:0] limit;

    generate
        for (genvar g = 0; g < DIV_W; g++) begin : g_mask
            assign limit[g] = (pre_exp > PRE_W'(g));
        end
    endgenerate

    assign tick = (pcnt == limit);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pcnt <= '0;
        end else if (restart || tick) begin
            pcnt <= '0;
        end else begin
            pcnt <= pcnt + DIV_W'(1);
        end
    end

endmodule

// File: rtl/sclt_phase.sv
// Counts prescaled ticks since the current phase began.
module sclt_phase #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             tick,
    output logic [CNT_W-1:0] cnt
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (restart) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= cnt + CNT_W'(1);
        end
    end

endmodule

// File: rtl/i2c_scl_timer.sv
module i2c_scl_timer
    import sclt_pkg::*;
#(
    parameter int PRE_W = 3,
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             auto_cfg,
    input  logic [PRE_W-1:0] pre_exp,
    input  logic [CNT_W-1:0] clkhi_cnt,
    input  logic [CNT_W-1:0] clklo_cnt,
    input  logic [CNT_W-1:0] sethold_cnt,
    input  logic [CNT_W-1:0] datavd_cnt,
    input  logic             cmd_valid,
    input  logic [1:0]       cmd_code,
    output logic             cmd_ready,
    input  logic             scl_in,
    output logic             scl_o,
    output logic             start_stb,
    output logic             stop_stb,
    output logic             drive_stb,
    output logic             sample_stb
);

    sclt_state_e      state_q, state_d;
    sclt_cmd_e        cmd_e;
    logic [PRE_W-1:0] eff_pre;
    logic [CNT_W-1:0] eff_hi, eff_lo, eff_sh, eff_dv;
    logic [CNT_W-1:0] ph_cnt, ph_lim;
    logic             tick, last, restart;
    logic             scl_seen;
    logic             op_stop_q;
    logic             want_start, want_bit;

    sclt_cfg #(.PRE_W(PRE_W), .CNT_W(CNT_W)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en),
        .auto_cfg   (auto_cfg),
        .pre_exp    (pre_exp),
        .clkhi_cnt  (clkhi_cnt),
        .clklo_cnt  (clklo_cnt),
        .sethold_cnt(sethold_cnt),
        .datavd_cnt (datavd_cnt),
        .eff_pre    (eff_pre),
        .eff_hi     (eff_hi),
        .eff_lo     (eff_lo),
        .eff_sh     (eff_sh),
        .eff_dv     (eff_dv)
    );

    sclt_tick #(.PRE_W(PRE_W)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .restart(restart),
        .pre_exp(eff_pre),
        .tick   (tick)
    );

    sclt_phase #(.CNT_W(CNT_W)) u_phase (
        .clk    (clk),
        .rst_n  (rst_n),
        .restart(restart),
        .tick   (tick),
        .cnt    (ph_cnt)
    );

    assign cmd_e      = sclt_cmd_e'(cmd_code);
    assign want_start = cmd_valid && (cmd_e == CMD_START);
    assign want_bit   = cmd_valid && ((cmd_e == CMD_BIT) || (cmd_e == CMD_STOP));

    // tick limit of the phase being timed
    always_comb begin
        unique case (state_q)
            ST_START_SU, ST_START_HD, ST_STOP_SU: ph_lim = eff_sh;
            ST_LOW:                               ph_lim = eff_lo;
            ST_HIGH:                              ph_lim = eff_hi;
            default:                              ph_lim = '0;
        endcase
    end

    assign last      = tick && (ph_cnt == ph_lim);
    assign cmd_ready = en && ((state_q == ST_IDLE) || (state_q == ST_PARK) ||
                              ((state_q == ST_HIGH) && last));

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (want_start) state_d = ST_START_SU;
            ST_START_SU: if (last)       state_d = ST_START_HD;
            ST_START_HD: if (last)       state_d = ST_PARK;
            ST_PARK:     if (want_bit)   state_d = ST_LOW;
            ST_LOW:      if (last)       state_d = ST_WAIT_HI;
            ST_WAIT_HI:  if (scl_seen)   state_d = op_stop_q ? ST_STOP_SU : ST_HIGH;
            ST_HIGH:     if (last)       state_d = want_bit ? ST_LOW : ST_PARK;
            ST_STOP_SU:  if (last)       state_d = ST_IDLE;
        endcase
        if (!en) begin
            state_d = ST_IDLE;
        end
    end

    assign restart = (state_d != state_q);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // line sampler and latched kind of the running bit cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_seen  <= 1'b0;
            op_stop_q <= 1'b0;
        end else begin
            scl_seen <= scl_in;
            if (cmd_ready && want_bit && (state_q != ST_IDLE)) begin
                op_stop_q <= (cmd_e == CMD_STOP);
            end
        end
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_o      <= 1'b1;
            start_stb  <= 1'b0;
            stop_stb   <= 1'b0;
            drive_stb  <= 1'b0;
            sample_stb <= 1'b0;
        end else begin
            scl_o      <= !((state_d == ST_LOW) || (state_d == ST_PARK));
            start_stb  <= (state_q == ST_START_SU) && (state_d == ST_START_HD);
            stop_stb   <= en && (state_q == ST_STOP_SU) && last;
            drive_stb  <= en && (state_q == ST_LOW) && tick && (ph_cnt == eff_dv);
            sample_stb <= (state_q == ST_WAIT_HI) && (state_d == ST_HIGH);
        end
    end

endmodule

module sclt_checker (
    input logic clk,
    input logic rst_n,
    input logic en,
    input logic scl_in,
    input logic scl_o,
    input logic start_stb,
    input logic stop_stb,
    input logic drive_stb,
    input logic sample_stb
);

    assert_release_when_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> scl_o);

    assert_sample_after_line_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb |-> $past(scl_in, 2));

    assert_start_scl_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
        start_stb |-> scl_o);

    assert_stop_scl_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
        stop_stb |-> scl_o);

    assert_drive_after_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        drive_stb |-> !$past(scl_o));

    assert_one_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({start_stb, stop_stb, drive_stb, sample_stb}));

endmodule

bind i2c_scl_timer sclt_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .scl_in    (scl_in),
    .scl_o     (scl_o),
    .start_stb (start_stb),
    .stop_stb  (stop_stb),
    .drive_stb (drive_stb),
    .sample_stb(sample_stb)
);

// File: tb/sim_i2c_scl_timer.sv
`timescale 1ns/1ps
module sim_i2c_scl_timer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic       auto_cfg = 1'b0;
    logic [2:0] pre_exp = '0;
    logic [5:0] clkhi_cnt = 6'd1, clklo_cnt = 6'd2, sethold_cnt = 6'd1, datavd_cnt = 6'd0;
    logic       cmd_valid = 1'b0;
    logic [1:0] cmd_code = 2'd0;
    logic       cmd_ready, scl_o, scl_in;
    logic       start_stb, stop_stb, drive_stb, sample_stb;
    logic       stretch = 1'b0;

    int cyc = 0;
    int n_cmp = 0, n_bad = 0;
    int n_start = 0, n_stop = 0, n_drv = 0, n_smp = 0;

    always #4 clk = ~clk;

    assign scl_in = scl_o & ~stretch;

    i2c_scl_timer u0 (
        .clk(clk), .rst_n(rst_n), .en(en), .auto_cfg(auto_cfg), .pre_exp(pre_exp),
        .clkhi_cnt(clkhi_cnt), .clklo_cnt(clklo_cnt), .sethold_cnt(sethold_cnt),
        .datavd_cnt(datavd_cnt), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .cmd_ready(cmd_ready), .scl_in(scl_in), .scl_o(scl_o), .start_stb(start_stb),
        .stop_stb(stop_stb), .drive_stb(drive_stb), .sample_stb(sample_stb)
    );

    always @(posedge clk) begin
        cyc = cyc + 1;
        if (rst_n) begin
            if (start_stb)  n_start = n_start + 1;
            if (stop_stb)   n_stop  = n_stop + 1;
            if (drive_stb)  n_drv   = n_drv + 1;
            if (sample_stb) n_smp   = n_smp + 1;
        end
    end

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp = n_cmp + 1;
        n_bad = n_bad + 1;
        $display("FAIL watchdog: actual=hung expected=finished");
        summary();
        $finish;
    end

    task automatic chk(input string req, input int act, input int exp);
        n_cmp = n_cmp + 1;
        if (act != exp) begin
            n_bad = n_bad + 1;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // kind: 0 scl rise, 1 scl fall, 2 start, 3 stop, 4 drive, 5 sample
    task automatic wait_ev(input string req, input int kind, output int t);
        logic prev;
        bit   hit;
        prev = scl_o;
        hit  = 1'b0;
        t    = -1;
        for (int n = 0; n < 5000 && !hit; n++) begin
            @(negedge clk);
            case (kind)
                0: hit = scl_o && !prev;
                1: hit = !scl_o && prev;
                2: hit = start_stb;
                3: hit = stop_stb;
                4: hit = drive_stb;
                5: hit = sample_stb;
                default: hit = 1'b0;
            endcase
            prev = scl_o;
        end
        if (hit) t = cyc;
        else begin
            n_cmp = n_cmp + 1;
            n_bad = n_bad + 1;
            $display("FAIL %s: actual=timeout expected=event%0d", req, kind);
        end
    endtask

    task automatic send(input logic [1:0] c, output int t);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_code  = c;
        for (int n = 0; n < 5000 && !cmd_ready; n++) @(negedge clk);
        t = cyc + 1;
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_code  = 2'd0;
    endtask

    task automatic cfg_apply(input int p, input int hi, input int lo, input int sh,
                             input int dv, input bit au);
        @(negedge clk);
        en          = 1'b0;
        stretch     = 1'b0;
        pre_exp     = 3'(p);
        clkhi_cnt   = 6'(hi);
        clklo_cnt   = 6'(lo);
        sethold_cnt = 6'(sh);
        datavd_cnt  = 6'(dv);
        auto_cfg    = au;
        repeat (3) @(negedge clk);
        en = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1", scl_o, 1);
        chk("R1", cmd_ready, 0);
        chk("R1", start_stb | stop_stb | drive_stb | sample_stb, 0);
    endtask

    // START, two bits, STOP; every interval checked against the formulas
    task automatic t_frame(input string lo_req, input int p, input int hi, input int lo,
                           input int sh, input int dv, input bit au);
        int P, elo, esh, edv, per, s0;
        int ts, t1, t2, ta1, td, tr, tsm, ta2, ta3, tr3, tst;
        P = 1 << p;
        if (au) begin
            if (hi < 2) begin elo = 3; esh = 2; edv = 1; end
            else begin elo = 2 * hi; esh = hi; edv = hi / 2; end
        end else begin
            elo = lo; esh = sh; edv = dv;
        end
        per = P * (hi + elo + 2) + 2;
        cfg_apply(p, hi, lo, sh, dv, au);
        s0 = n_smp;
        send(2'd1, ts);
        wait_ev("R6", 2, t1);  chk("R6", t1 - ts, (esh + 1) * P);
        wait_ev("R6", 1, t2);  chk("R6", t2 - t1, (esh + 1) * P);
        send(2'd2, ta1);
        wait_ev("R8", 4, td);      chk("R8", td - ta1, (edv + 1) * P);
        wait_ev(lo_req, 0, tr);    chk(lo_req, tr - ta1, (elo + 1) * P);
        wait_ev("R4", 5, tsm);     chk("R4", tsm - tr, 2);
        send(2'd2, ta2);
        chk("R2", ta2 - tsm, (hi + 1) * P);
        chk("R5", ta2 - ta1, per);
        send(2'd3, ta3);
        chk("R5", ta3 - ta2, per);
        wait_ev("R7", 0, tr3);  chk("R7", tr3 - ta3, (elo + 1) * P);
        wait_ev("R7", 3, tst);  chk("R7", tst - tr3, 2 + (esh + 1) * P);
        @(negedge clk);
        chk("R7", cmd_ready, 1);
        chk("R7", scl_o, 1);
        chk("R9", n_smp - s0, 2);
    endtask

    task automatic t_stretch();
        int t, ta, tr, trel, tsm, s0;
        cfg_apply(0, 3, 4, 1, 1, 1'b0);
        send(2'd1, t);
        wait_ev("R4", 1, t);
        send(2'd2, ta);
        stretch = 1'b1;
        wait_ev("R4", 0, tr);
        s0 = n_smp;
        repeat (10) @(negedge clk);
        chk("R4", n_smp - s0, 0);
        stretch = 1'b0;
        trel = cyc;
        wait_ev("R4", 5, tsm);
        chk("R4", tsm - trel, 2);
        send(2'd3, t);
        wait_ev("R7", 3, t);
    endtask

    task automatic t_locked();
        int t, ta, tr;
        cfg_apply(1, 2, 4, 1, 1, 1'b0);
        clklo_cnt = 6'd20;
        pre_exp   = 3'd3;
        clkhi_cnt = 6'd9;
        send(2'd1, t);
        wait_ev("R12", 1, t);
        send(2'd2, ta);
        wait_ev("R12", 0, tr);
        chk("R12", tr - ta, 5 * 2);
        send(2'd3, t);
        wait_ev("R12", 3, t);
    endtask

    task automatic t_ignored();
        int t, ta, tr, s0, d0, p0;
        cfg_apply(0, 2, 3, 1, 1, 1'b0);
        s0 = n_start; d0 = n_drv; p0 = n_smp;
        send(2'd2, t);
        send(2'd3, t);
        repeat (20) @(negedge clk);
        chk("R13", scl_o, 1);
        chk("R13", n_start + n_drv + n_smp - s0 - d0 - p0, 0);
        send(2'd1, t);
        wait_ev("R13", 1, t);
        s0 = n_start;
        send(2'd1, t);
        repeat (20) @(negedge clk);
        chk("R13", scl_o, 0);
        chk("R13", n_start - s0, 0);
        send(2'd2, ta);
        wait_ev("R13", 0, tr);
        chk("R13", tr - ta, 4);
        send(2'd3, t);
        wait_ev("R13", 3, t);
    endtask

    task automatic t_disable();
        int t, s0;
        cfg_apply(1, 4, 8, 2, 2, 1'b0);
        send(2'd1, t);
        wait_ev("R1", 1, t);
        send(2'd2, t);
        @(negedge clk);
        chk("R1", scl_o, 0);
        en = 1'b0;
        @(negedge clk);
        chk("R1", scl_o, 1);
        chk("R1", cmd_ready, 0);
        s0 = n_drv + n_smp + n_start + n_stop;
        repeat (30) @(negedge clk);
        chk("R1", scl_o, 1);
        chk("R1", n_drv + n_smp + n_start + n_stop - s0, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_frame("R3", 0, 3, 5, 2, 1, 1'b0);
        t_frame("R3", 2, 4, 6, 3, 2, 1'b0);
        t_frame("R10", 1, 5, 0, 0, 0, 1'b1);
        t_frame("R11", 0, 1, 0, 0, 0, 1'b1);
        t_stretch();
        t_locked();
        t_ignored();
        t_disable();
        summary();
        $finish;
    end

endmodule